// File: doc/BRIEF.md
# Filtered PI Gate Position Controller

This block closes a downstream water-level loop by computing a commanded gate opening. On every accepted sample strobe it takes an 8-bit measured level and an 8-bit target level and forms the error target minus level. The level sensor sits just upstream of the next check structure downstream, so a level below target asks for a wider opening. The error is smoothed by a first-order exponential filter whose time constant can be set over a long range. A proportional-plus-integral law then acts on the filtered error, and a separate overall reach gain scales the result into a position command from 0 to 255.

The three gains and the time constant are static inputs that a reach configuration supplies. The integral uses conditional integration: it is held whenever the output is pinned at a limit and the error pushes further into that limit. The opening register holds its value between samples. A one-cycle valid pulse marks each update.

Top module: `level_pi_gate`

## Requirements
- R1: While `rst_n` is low and on release, `gateOut` is 0 and `validOut` is 0. Reset also clears the filter state and the integral.
- R2: A sample is accepted at a rising clock edge where `sampleStb` and `enableIn` are both 1. `validOut` is 1 for exactly the cycle after that edge, and `gateOut` takes its new value at the same edge. `gateOut` holds in every other cycle.
- R3: The raw error is the integer `targetIn - levelIn`, from -255 to +255. A positive value drives the opening up.
- R4: The filter state F has 16 fractional bits and starts at 0. On each sample, F += floor(((raw << 16) - F) * a / 65536), where a = floor(65536 / T). The filtered error used below is e = floor(F / 256), with 8 fractional bits.
- R5: The candidate integral is Ic = I + K2*e, with `k2In` holding 8 fractional bits. Ic saturates to +/-(2^29 - 1).
- R6: The opening is floor(K3*(16*K1*e + I) / 2^20), clamped to 0..255. `k1In` and `k3In` each hold 4 fractional bits, and I is the integral after the R7 decision.
- R7: The candidate opening is evaluated with Ic. If it exceeds 255 while e > 0, or is below 0 while e < 0, the integral keeps its previous value. Otherwise it becomes Ic.
- R8: When `enableIn` is 0, strobes have no effect. No valid pulse is produced, and neither the filter, the integral nor `gateOut` changes.
- R9: Strobes on consecutive cycles are each accepted as separate samples.
- R10: The time constant T is `tauIn` limited to the range 500..1300. A value below 500 acts as 500 and a value above 1300 acts as 1300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | Sample strobe, one cycle per sample |
| levelIn | input | 8 | Measured downstream level |
| targetIn | input | 8 | Target level |
| k1In | input | 8 | Proportional gain, 4 fractional bits |
| k2In | input | 8 | Integral gain, 8 fractional bits |
| k3In | input | 8 | Overall reach gain, 4 fractional bits |
| tauIn | input | 11 | Filter time constant in sample periods |
| enableIn | input | 1 | Accept strobes when 1 |
| gateOut | output | 8 | Commanded gate opening |
| validOut | output | 1 | One-cycle pulse after each accepted sample |

## Verification
The output clamp and the integral freeze are decided in the same cycle. Whether the integral moves depends on where the candidate opening falls relative to the limit. This is provoked by driving full-scale error with maximum gains until the opening pins at 255. The error is then reversed, and the bench judges the freeze by comparing every cycle of the wind-down against a behavioural model. A design that kept integrating would need many more samples to leave the limit.

// File: rtl/gatepi_pkg.sv
package gatepi_pkg;
  // wide signed intermediate for the fixed-point datapath
  typedef logic signed [63:0] wide_t;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // accept the present sample and update all state
  } gp_ctl_t;
endpackage

// File: rtl/gatepi_ctrl.sv
module gatepi_ctrl
  import gatepi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sampleStb,
  input  logic    enableIn,
  output gp_ctl_t ctl,
  output logic    validOut
);
  always_comb begin
    ctl.step = sampleStb & enableIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validOut <= 1'b0;
    else        validOut <= ctl.step;
  end
endmodule

// File: rtl/gatepi_dpath.sv
module gatepi_dpath
  import gatepi_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int GAIN_W     = 8,
  parameter int TAU_W      = 11,
  parameter int TAU_MIN    = 500,
  parameter int TAU_MAX    = 1300,
  parameter int ALPHA_FRAC = 16,
  parameter int ERR_FRAC   = 8,
  parameter int K1_FRAC    = 4,
  parameter int K2_FRAC    = 8,
  parameter int K3_FRAC    = 4,
  parameter int INT_W      = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gp_ctl_t           ctl,
  input  logic [LVL_W-1:0]  levelIn,
  input  logic [LVL_W-1:0]  targetIn,
  input  logic [GAIN_W-1:0] k1In,
  input  logic [GAIN_W-1:0] k2In,
  input  logic [GAIN_W-1:0] k3In,
  input  logic [TAU_W-1:0]  tauIn,
  output logic [LVL_W-1:0]  gateOut
);
  localparam int    FW      = LVL_W + 2 + ALPHA_FRAC;
  localparam int    F2E     = ALPHA_FRAC - ERR_FRAC;
  localparam int    P_ALIGN = K2_FRAC - K1_FRAC;
  localparam int    OUT_SH  = ERR_FRAC + K2_FRAC + K3_FRAC;
  localparam wide_t ONE_A   = wide_t'(1) <<< ALPHA_FRAC;
  localparam wide_t IMAX    = (wide_t'(1) <<< (INT_W - 1)) - 1;
  localparam wide_t OMAX    = (wide_t'(1) <<< LVL_W) - 1;

  logic signed [FW-1:0]    filtQ;
  logic signed [INT_W-1:0] intQ;
  logic [LVL_W-1:0]        gateQ;

  wide_t tauW, alphaW, eRawW, filtW, diffW, stepW, filtNxtW, errW;
  wide_t k1W, k2W, k3W, intW, pAlW, icW, icSatW, rawCW, intNewW, rawFW;
  logic  freeze;
  logic [LVL_W-1:0] gateNxt;

  // filter coefficient from the limited time constant
  always_comb begin
    tauW = wide_t'(tauIn);
    if (tauW < wide_t'(TAU_MIN))      tauW = wide_t'(TAU_MIN);
    else if (tauW > wide_t'(TAU_MAX)) tauW = wide_t'(TAU_MAX);
    alphaW = ONE_A / tauW;
  end

  // first-order filter of the raw error
  always_comb begin
    eRawW    = wide_t'(targetIn) - wide_t'(levelIn);
    filtW    = wide_t'(filtQ);
    diffW    = (eRawW <<< ALPHA_FRAC) - filtW;
    stepW    = (diffW * alphaW) >>> ALPHA_FRAC;
    filtNxtW = filtW + stepW;
    errW     = filtNxtW >>> F2E;
  end

  // proportional plus integral with conditional integration
  always_comb begin
    k1W  = wide_t'(k1In);
    k2W  = wide_t'(k2In);
    k3W  = wide_t'(k3In);
    intW = wide_t'(intQ);
    pAlW = (k1W * errW) <<< P_ALIGN;
    icW  = intW + k2W * errW;
    if (icW > IMAX)       icSatW = IMAX;
    else if (icW < -IMAX) icSatW = -IMAX;
    else                  icSatW = icW;
    rawCW  = (k3W * (pAlW + icSatW)) >>> OUT_SH;
    freeze = ((errW > 0) && (rawCW > OMAX)) || ((errW < 0) && (rawCW < 0));
    intNewW = freeze ? intW : icSatW;
    rawFW   = (k3W * (pAlW + intNewW)) >>> OUT_SH;
    if (rawFW < 0)         gateNxt = '0;
    else if (rawFW > OMAX) gateNxt = '1;
    else                   gateNxt = rawFW[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtQ <= '0;
      intQ  <= '0;
      gateQ <= '0;
    end else if (ctl.step) begin
      filtQ <= filtNxtW[FW-1:0];
      intQ  <= intNewW[INT_W-1:0];
      gateQ <= gateNxt;
    end
  end

  assign gateOut = gateQ;
endmodule

// File: rtl/level_pi_gate.sv
module level_pi_gate
  import gatepi_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int GAIN_W  = 8,
  parameter int TAU_W   = 11,
  parameter int TAU_MIN = 500,
  parameter int TAU_MAX = 1300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleStb,
  input  logic [LVL_W-1:0]  levelIn,
  input  logic [LVL_W-1:0]  targetIn,
  input  logic [GAIN_W-1:0] k1In,
  input  logic [GAIN_W-1:0] k2In,
  input  logic [GAIN_W-1:0] k3In,
  input  logic [TAU_W-1:0]  tauIn,
  input  logic              enableIn,
  output logic [LVL_W-1:0]  gateOut,
  output logic              validOut
);
  gp_ctl_t ctl;

  gatepi_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .enableIn(enableIn),
    .ctl(ctl), .validOut(validOut)
  );

  gatepi_dpath #(
    .LVL_W(LVL_W), .GAIN_W(GAIN_W), .TAU_W(TAU_W),
    .TAU_MIN(TAU_MIN), .TAU_MAX(TAU_MAX)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .levelIn(levelIn), .targetIn(targetIn),
    .k1In(k1In), .k2In(k2In), .k3In(k3In), .tauIn(tauIn), .gateOut(gateOut)
  );
endmodule

// File: rtl/level_pi_gate_chk.sv
module level_pi_gate_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleStb,
  input logic             enableIn,
  input logic [LVL_W-1:0] gateOut,
  input logic             validOut
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gateOut == '0 && !validOut)); // R1

  AST_VALID_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && enableIn) |=> validOut); // R2

  AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampleStb && enableIn) |=> !validOut); // R2

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !validOut |-> $stable(gateOut)); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enableIn |=> !validOut); // R8
endmodule

bind level_pi_gate level_pi_gate_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .enableIn(enableIn),
  .gateOut(gateOut), .validOut(validOut)
);

// File: tb/level_pi_gate_tb.sv
module level_pi_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleStb = 1'b0;
  logic [7:0]  levelIn = '0, targetIn = '0;
  logic [7:0]  k1In = '0, k2In = '0, k3In = '0;
  logic [10:0] tauIn = 11'd500;
  logic        enableIn = 1'b0;
  logic [7:0]  gateOut;
  logic        validOut;

  int    nChecks = 0;
  int    nErrors = 0;
  int    cycles  = 0;
  bit    done    = 1'b0;
  string curReq  = "R1";

  // reference model state
  longint mF = 0, mI = 0;
  int     expGate = 0;
  bit     expValid = 1'b0;

  level_pi_gate dut_i (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .levelIn(levelIn),
    .targetIn(targetIn), .k1In(k1In), .k2In(k2In), .k3In(k3In), .tauIn(tauIn),
    .enableIn(enableIn), .gateOut(gateOut), .validOut(validOut)
  );

  always #4 clk = ~clk;

  // behavioural model of the requirements, evaluated per accepted sample
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mF = 0; mI = 0; expGate = 0; expValid = 1'b0;
    end else if (sampleStb && enableIn) begin
      longint tau, a, raw, e, p, ic, cand, fin;
      tau = longint'(tauIn);
      if (tau < 500) tau = 500;            // R10
      if (tau > 1300) tau = 1300;
      a   = 65536 / tau;                   // R4
      raw = longint'(targetIn) - longint'(levelIn);   // R3
      mF  = mF + ((((raw * 65536) - mF) * a) >>> 16);
      e   = mF >>> 8;
      p   = 16 * longint'(k1In) * e;       // R6
      ic  = mI + longint'(k2In) * e;       // R5
      if (ic > 536870911)  ic = 536870911;
      if (ic < -536870911) ic = -536870911;
      cand = (longint'(k3In) * (p + ic)) >>> 20;
      if (!((e > 0 && cand > 255) || (e < 0 && cand < 0))) mI = ic;  // R7
      fin = (longint'(k3In) * (p + mI)) >>> 20;
      if (fin < 0) fin = 0;
      if (fin > 255) fin = 255;
      expGate  = int'(fin);
      expValid = 1'b1;
    end else begin
      expValid = 1'b0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      nChecks++;
      if (validOut !== expValid || int'(gateOut) !== expGate) begin
        nErrors++;
        $display("FAIL %s valid %0b exp %0b gate %0d exp %0d",
                 curReq, validOut, expValid, gateOut, expGate);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic samples(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      sampleStb = 1'b1; tick(1);
      sampleStb = 1'b0; tick(gap - 1);
    end
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  // watchdog
  initial begin
    #1_200_000;
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  int lcg = 12345;

  initial begin
    // R1: reset state
    tick(3);
    check("R1", int'(gateOut), 0);
    check("R1", int'(validOut), 0);
    rst_n = 1'b1; tick(2);
    check("R1", int'(gateOut), 0);
    enableIn = 1'b1;

    // R3 R4 R6: steady error, level below target
    curReq = "R4"; levelIn = 8'd100; targetIn = 8'd150;
    k1In = 8'd32; k2In = 8'd4; k3In = 8'd16; tauIn = 11'd500;
    samples(600, 4);
    curReq = "R3"; tick(1);
    nChecks++;
    if (gateOut == 0) begin
      nErrors++; $display("FAIL R3 gate %0d expected above 0", gateOut);
    end

    // R6: varied levels and target
    curReq = "R6"; tauIn = 11'd800;
    for (int i = 0; i < 400; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      levelIn = 8'(lcg >> 8); targetIn = 8'd128;
      samples(1, 3);
    end

    // R5 R7: full-scale error with maximum gains, then reversal
    curReq = "R7"; k1In = 8'd255; k2In = 8'd255; k3In = 8'd255;
    levelIn = 8'd0; targetIn = 8'd255; tauIn = 11'd500;
    samples(300, 3);
    check("R7", int'(gateOut), 255);
    curReq = "R5"; levelIn = 8'd255; targetIn = 8'd0;
    samples(300, 3);
    check("R7", int'(gateOut), 0);

    // R9: strobes on consecutive cycles
    curReq = "R9"; k1In = 8'd20; k2In = 8'd2; k3In = 8'd16;
    levelIn = 8'd90; targetIn = 8'd140;
    sampleStb = 1'b1; tick(200); sampleStb = 1'b0; tick(2);

    // R8: strobes while disabled are ignored
    curReq = "R8"; enableIn = 1'b0; levelIn = 8'd0; targetIn = 8'd255;
    samples(50, 3);
    enableIn = 1'b1; levelIn = 8'd90; targetIn = 8'd140;
    samples(20, 3);

    // R10: out-of-range time constants
    curReq = "R10"; tauIn = 11'd100; levelIn = 8'd60; targetIn = 8'd120;
    samples(200, 3);
    tauIn = 11'd2000; levelIn = 8'd200;
    samples(200, 3);

    // R1: reset in mid-run
    curReq = "R1"; rst_n = 1'b0; tick(2);
    check("R1", int'(gateOut), 0);
    check("R1", int'(validOut), 0);
    rst_n = 1'b1; tick(2);
    curReq = "R2"; tauIn = 11'd600; samples(30, 5);

    tick(4);
    finishRun();
  end
endmodule